// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Codec for 8-bit Data

This block protects an 8-bit value with a 13-bit code word. The encoder places four even-parity check bits at the power-of-two positions of a 12-position word. It then appends one more bit that makes the parity of the whole 13-bit word even. The decoder takes a received 13-bit word and recomputes the four group parities, which form a syndrome, together with the overall parity. From these it corrects any single flipped bit, or it flags a word that holds two errors as uncorrectable.

Both halves work on every clock with no handshake. Each output is registered, so a value presented before a rising edge appears at the outputs just after that edge. The encoder and decoder are independent and can be used at the same time, for example on the write and read sides of a memory.

Top module: `secded_codec`

## Requirements
- R1: Code word bit k-1 holds position k (k = 1..12), and bit 12 holds the overall parity bit. The data bits d[0]..d[7] of the input sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: The check bit at position 2^i (i = 0..3) makes the XOR of every position whose index has bit i set equal to 0. For example, input 8'hE3 encodes to 13'h0E97.
- R3: Bit 12 of the code word makes the XOR of all 13 bits equal to 0.
- R4: While reset is low, every output is 0. After reset, each output reflects the inputs sampled at the previous rising edge, one cycle of latency.
- R5: Syndrome bit i is the XOR of the received positions 1..12 whose index has bit i set.
- R6: If the syndrome is 0 and the overall parity is even, the decoder outputs the data bits unchanged, with both flags low.
- R7: If the syndrome s is in 1..12 and the overall parity is odd, position s is inverted before the data is extracted, and the corrected flag is set.
- R8: If the syndrome is 0 and the overall parity is odd, only the overall parity bit was hit. The data is output unchanged and the corrected flag is set.
- R9: If the syndrome is nonzero and the overall parity is even, the uncorrectable flag is set and the data bits are passed through unmodified.
- R10: If the syndrome is 13, 14 or 15 and the overall parity is odd, the uncorrectable flag is set and the data bits are passed through unmodified.
- R11: The corrected flag and the uncorrectable flag are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_msg | input | 8 | Data to encode |
| enc_word | output | 13 | Registered code word |
| dec_word | input | 13 | Received code word |
| dec_msg | output | 8 | Registered decoded data |
| dec_syndrome | output | 4 | Registered syndrome |
| dec_corr | output | 1 | A single error was found and corrected |
| dec_uncorr | output | 1 | The word cannot be corrected |

## Verification
On every cycle the assertions check that the two flags are mutually exclusive and that the code word has even overall parity. They also check that the data bits of the code word and the passed-through data match the inputs of the previous cycle, and that the corrected flag only follows a received word of odd parity. Two things need the bench's reference model: that the check bits land on the right positions with the right values, and that an error at each position is repaired to exactly the original data. To show these, the bench encodes all 256 inputs, including the worked example, and decodes all 8192 possible received words.

// File: rtl/secded_codec.sv
module secded_codec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  enc_msg,
  output logic [12:0] enc_word,
  input  logic [12:0] dec_word,
  output logic [7:0]  dec_msg,
  output logic [3:0]  dec_syndrome,
  output logic        dec_corr,
  output logic        dec_uncorr
);

  logic [3:0]  chk;
  logic [11:0] cw;

  assign chk[0] = enc_msg[0] ^ enc_msg[1] ^ enc_msg[3] ^ enc_msg[4] ^ enc_msg[6];
  assign chk[1] = enc_msg[0] ^ enc_msg[2] ^ enc_msg[3] ^ enc_msg[5] ^ enc_msg[6];
  assign chk[2] = enc_msg[1] ^ enc_msg[2] ^ enc_msg[3] ^ enc_msg[7];
  assign chk[3] = enc_msg[4] ^ enc_msg[5] ^ enc_msg[6] ^ enc_msg[7];

  assign cw = {enc_msg[7:4], chk[3], enc_msg[3:1], chk[2], enc_msg[0], chk[1], chk[0]};

  logic [3:0]  syn;
  logic        odd;
  logic        in_range;
  logic        fix_pos;
  logic [11:0] flip;
  logic [11:0] fixed;

  assign syn[0] = dec_word[0] ^ dec_word[2] ^ dec_word[4] ^ dec_word[6] ^ dec_word[8] ^ dec_word[10];
  assign syn[1] = dec_word[1] ^ dec_word[2] ^ dec_word[5] ^ dec_word[6] ^ dec_word[9] ^ dec_word[10];
  assign syn[2] = dec_word[3] ^ dec_word[4] ^ dec_word[5] ^ dec_word[6] ^ dec_word[11];
  assign syn[3] = dec_word[7] ^ dec_word[8] ^ dec_word[9] ^ dec_word[10] ^ dec_word[11];

  assign odd      = ^dec_word;
  assign in_range = (syn <= 4'd12);
  assign fix_pos  = odd && (syn != 4'd0) && in_range;

  always_comb begin
    for (int k = 1; k <= 12; k++)
      flip[k-1] = fix_pos && (syn == 4'(k));
  end

  assign fixed = dec_word[11:0] ^ flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_word     <= '0;
      dec_msg      <= '0;
      dec_syndrome <= '0;
      dec_corr     <= 1'b0;
      dec_uncorr   <= 1'b0;
    end else begin
      enc_word     <= {^cw, cw};
      dec_msg      <= {fixed[11:8], fixed[6:4], fixed[2]};
      dec_syndrome <= syn;
      dec_corr     <= odd && in_range;
      dec_uncorr   <= (!odd && (syn != 4'd0)) || (odd && !in_range);
    end
  end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  enc_msg,
  input logic [12:0] enc_word,
  input logic [12:0] dec_word,
  input logic [7:0]  dec_msg,
  input logic [3:0]  dec_syndrome,
  input logic        dec_corr,
  input logic        dec_uncorr
);

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  function automatic logic [7:0] raw_data(input logic [12:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  a_r1_data_positions: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> raw_data(enc_word) == $past(enc_msg));

  a_r3_even_word: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (^enc_word) == 1'b0);

  a_r6_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !dec_corr && !dec_uncorr) |-> (dec_syndrome == 4'd0 && dec_msg == raw_data($past(dec_word))));

  a_r7_corr_needs_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (live && dec_corr) |-> (^$past(dec_word)) == 1'b1);

  a_r8_parity_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (live && dec_corr && dec_syndrome == 4'd0) |-> dec_msg == raw_data($past(dec_word)));

  a_r9_raw_on_uncorr: assert property (@(posedge clk) disable iff (!rst_n)
    (live && dec_uncorr) |-> dec_msg == raw_data($past(dec_word)));

  a_r10_high_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (live && dec_syndrome > 4'd12) |-> dec_uncorr);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_corr, dec_uncorr}));

endmodule

bind secded_codec secded_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enc_msg(enc_msg), .enc_word(enc_word),
  .dec_word(dec_word), .dec_msg(dec_msg), .dec_syndrome(dec_syndrome),
  .dec_corr(dec_corr), .dec_uncorr(dec_uncorr)
);

// File: tb/tb_secded_codec.sv
`timescale 1ns/1ps
module tb_secded_codec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  enc_msg = '0;
  logic [12:0] enc_word;
  logic [12:0] dec_word = '0;
  logic [7:0]  dec_msg;
  logic [3:0]  dec_syndrome;
  logic        dec_corr;
  logic        dec_uncorr;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  secded_codec dut (
    .clk(clk), .rst_n(rst_n), .enc_msg(enc_msg), .enc_word(enc_word),
    .dec_word(dec_word), .dec_msg(dec_msg), .dec_syndrome(dec_syndrome),
    .dec_corr(dec_corr), .dec_uncorr(dec_uncorr)
  );

  int data_pos[8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  function automatic logic [12:0] ref_enc(input logic [7:0] m);
    logic [12:0] w;
    w = '0;
    for (int j = 0; j < 8; j++) w[data_pos[j]-1] = m[j];
    for (int i = 0; i < 4; i++) begin
      logic p;
      p = 1'b0;
      for (int q = 1; q <= 12; q++)
        if ((q >> i) & 1) p = p ^ w[q-1];
      w[(1 << i) - 1] = p;
    end
    w[12] = ^w[11:0];
    return w;
  endfunction

  function automatic void ref_dec(input logic [12:0] w, output logic [7:0] m,
                                  output logic [3:0] s, output logic c,
                                  output logic u, output string tag);
    int acc;
    logic [12:0] fx;
    logic par;
    acc = 0;
    for (int q = 1; q <= 12; q++) if (w[q-1]) acc = acc ^ q;
    s = 4'(acc);
    par = ^w;
    fx = w;
    c = 1'b0;
    u = 1'b0;
    if (!par && acc == 0) tag = "R6";
    else if (par && acc == 0) begin c = 1'b1; tag = "R8"; end
    else if (par && acc <= 12) begin c = 1'b1; fx[acc-1] = ~fx[acc-1]; tag = "R7"; end
    else if (par) begin u = 1'b1; tag = "R10"; end
    else begin u = 1'b1; tag = "R9"; end
    for (int j = 0; j < 8; j++) m[j] = fx[data_pos[j]-1];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] m, input logic [12:0] w);
    logic [12:0] ew;
    logic [7:0] em;
    logic [3:0] es;
    logic ec, eu;
    string tag;
    enc_msg = m;
    dec_word = w;
    @(posedge clk);
    #2;
    ew = ref_enc(m);
    ref_dec(w, em, es, ec, eu, tag);
    check("R1", "data bits", 32'({enc_word[11:8], enc_word[6:4], enc_word[2]}), 32'({ew[11:8], ew[6:4], ew[2]}));
    check("R2", "check bits", 32'({enc_word[7], enc_word[3], enc_word[1:0]}), 32'({ew[7], ew[3], ew[1:0]}));
    check("R3", "overall bit", 32'(enc_word[12]), 32'(ew[12]));
    check("R5", "syndrome", 32'(dec_syndrome), 32'(es));
    check(tag, "message", 32'(dec_msg), 32'(em));
    check(tag, "flags", 32'({dec_corr, dec_uncorr}), 32'({ec, eu}));
    check("R11", "flag overlap", 32'(dec_corr & dec_uncorr), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    enc_msg = 8'hFF;
    dec_word = 13'h1FFF;
    repeat (3) @(posedge clk);
    #2;
    check("R4", "reset enc_word", 32'(enc_word), 32'd0);
    check("R4", "reset dec outputs", 32'({dec_msg, dec_syndrome, dec_corr, dec_uncorr}), 32'd0);
    rst_n = 1'b1;

    step(8'hE3, 13'h0);
    check("R2", "worked example", 32'(enc_word), 32'h0E97);

    enc_msg = 8'h5A;
    @(posedge clk);
    #2;
    enc_msg = 8'hA5;
    check("R4", "one-cycle latency", 32'(enc_word), 32'(ref_enc(8'h5A)));

    for (int v = 0; v < 256; v++) step(8'(v), ref_enc(8'(v)));

    for (int b = 0; b < 13; b++) step(8'h3C, ref_enc(8'h3C) ^ (13'd1 << b));
    step(8'h00, ref_enc(8'h00) ^ 13'h1000);
    step(8'h81, ref_enc(8'h81) ^ 13'h0011);

    for (int w = 0; w < 8192; w++) step(8'(w), 13'(w));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule